// File: doc/BRIEF.md
# Reciprocal Square-Root Estimator

The block returns an 8-bit-accurate approximation of 1/sqrt(x) for an IEEE-754 operand. The operand is either single precision (in the low 32 bits of the input word) or double precision (the full 64 bits), chosen per operation. The block is one registered stage. An operand is presented with `in_valid`, and the result word appears on the next cycle together with `out_valid`.

Three sticky flags report exceptions: invalid operation, divide-by-zero, and input-denormal flushed. Each flag holds until `flag_clr` is pulsed.

For finite positive operands, the block finds the operand's leading one, normalising subnormals when flushing is off. It forms a 9-bit table index whose top bit encodes the parity of the unbiased exponent, and reads an 8-bit estimate from a table. That table is computed when the design is elaborated. Special operands bypass the table:
- NaNs are propagated, or replaced by the canonical NaN.
- Zeros give infinity.
- Negative operands give the default NaN.
- Positive infinity gives zero.

The result exponent is roughly minus half the operand's exponent.

Top module: `rsqrt_estimator`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_res` changes only in the cycle after an accepted operand. After reset, `out_valid`, `out_res` and all flags are 0.
- R2: With `in_dbl`=1 the operand is `in_op[63:0]` (sign bit 63, 11-bit exponent, 52-bit fraction). With `in_dbl`=0 the operand is `in_op[31:0]` (sign bit 31, 8-bit exponent, 23-bit fraction). In that case `in_op[63:32]` is ignored and `out_res[63:32]` is 0.
- R3: A quiet NaN (exponent all ones, top fraction bit 1) is returned unchanged. A signalling NaN (exponent all ones, top fraction bit 0, fraction nonzero) is returned with its top fraction bit set and raises `flag_ioc`.
- R4: With `ctl_dnan`=1 every NaN operand returns the canonical NaN: 0x7FC00000 for single, 0x7FF8000000000000 for double. A signalling NaN still raises `flag_ioc`.
- R5: A zero of either sign returns infinity of the same sign and raises `flag_dzc`.
- R6: A nonzero, non-NaN operand with the sign bit set (including -infinity) returns the canonical NaN and raises `flag_ioc`.
- R7: Positive infinity returns +0 and raises no flag.
- R8: For a finite positive operand, let u be the unbiased exponent of its leading one. The result has sign 0 and unbiased exponent floor(-(u+1)/2). Its top 8 fraction bits hold the table entry, and all lower fraction bits are 0.
- R9: For even u, the index is the leading one plus the next 7 significand bits (128..255). For odd u, it is the leading one plus the next 8 bits (256..511). For index i the entry is built as follows: let a = 2i+1 when i<256, else a = (i OR 1)*2. Let c be the smallest integer of at least 513 with a*c^2 >= 2^28. The entry is floor(c/2) mod 256.
- R10: With `ctl_ftz`=0, a subnormal operand is normalised by its leading-one position and then handled as in R8 and R9.
- R11: With `ctl_ftz`=1, a subnormal operand is treated as a zero of its own sign, as in R5, and also raises `flag_idc`.
- R12: Flags are sticky. `flag_clr` clears them at the next edge. An exception raised by an operand accepted in the same cycle as `flag_clr` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | Operand word |
| in_dbl | input | 1 | 1 = double precision, 0 = single in low half |
| ctl_ftz | input | 1 | Flush subnormal operands to zero |
| ctl_dnan | input | 1 | Return canonical NaN for any NaN operand |
| flag_clr | input | 1 | Clear all sticky flags |
| out_valid | output | 1 | Result valid |
| out_res | output | 64 | Result word, zero-extended for single |
| flag_ioc | output | 1 | Sticky invalid-operation flag |
| flag_dzc | output | 1 | Sticky divide-by-zero flag |
| flag_idc | output | 1 | Sticky input-denormal flag |

## Verification
The bench targets four corner areas, each with a characteristic failure:
- Exponent-parity split: a design that mixed up even and odd exponents would pick entries from the wrong half of the table, giving estimates off by about a factor of sqrt(2). The bench checks exact words at 1.0, 2.0 and 4.0 and at random operands.
- Subnormals: the smallest subnormals force a left shift when forming the index, and a normaliser that truncated there would produce index 0 and a zero fraction. With flushing on, a missing input-denormal flag or a sign lost on the resulting infinity shows up directly.
- NaNs: a NaN that was not quietened, or that ignored default-NaN mode, would change the returned word.
- Sticky flags: a flag that failed to survive later clean operands, or that was lost when a clear coincided with a new exception, would miscompare at the flag ports.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

   localparam int XW     = 64;   // operand/result word width
   localparam int IDX_W  = 9;    // estimate table index width
   localparam int EST_W  = 8;    // estimate width
   localparam int NFMT   = 2;    // 0: single, 1: double

   typedef enum logic [2:0] {
      K_FIN  = 3'd0,
      K_ZERO = 3'd1,
      K_INF  = 3'd2,
      K_QNAN = 3'd3,
      K_SNAN = 3'd4
   } kind_e;

   function automatic int fmt_exp_w(input int f);
      return (f == 0) ? 8 : 11;
   endfunction

   function automatic int fmt_frac_w(input int f);
      return (f == 0) ? 23 : 52;
   endfunction

   // Table entry: smallest c >= 513 with a*c*c >= 2^28, entry = c/2 mod 256.
   // Found by a fixed-depth bitwise search for the largest c with a*c*c < 2^28.
   function automatic logic [EST_W-1:0] est_entry(input int i);
      longint a, c, t;
      if (i < 128) return '0;
      a = (i < 256) ? longint'(2 * i + 1) : longint'((i | 1) * 2);
      c = 0;
      for (int k = 10; k >= 0; k--) begin
         t = c | (longint'(1) << k);
         if (a * t * t < longint'(268435456)) c = t;
      end
      c = c + 1;
      if (c < 513) c = 513;
      return EST_W'(c >> 1);
   endfunction

endpackage

// File: rtl/rsqrt_lut.sv
module rsqrt_lut
   import rsqrt_pkg::*;
#(
   parameter int TIDX_W = IDX_W,
   parameter int TEST_W = EST_W
) (
   input  logic [TIDX_W-1:0] idx,
   output logic [TEST_W-1:0] est
);
   localparam int DEPTH = 2 ** TIDX_W;

   if (TIDX_W != 9 || TEST_W != 8) begin : g_bad_geom
      $error("rsqrt_lut: table geometry is fixed at 9-bit index, 8-bit entry");
   end

   logic [TEST_W-1:0] tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign tbl[g] = est_entry(g);
   end

   assign est = tbl[idx];

endmodule

// File: rtl/rsqrt_unpack.sv
module rsqrt_unpack
   import rsqrt_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W-1:0] mag,
   input  logic                    ftz,
   output kind_e                   kind,
   output logic                    flushed,
   output logic [IDX_W-1:0]        idx,
   output logic [EXP_W-1:0]        rexp_b
);
   localparam int BIAS = 2 ** (EXP_W - 1) - 1;
   localparam int SW   = EXP_W + 3;
   localparam int LZW  = $clog2(FRAC_W + 2);

   if (FRAC_W < IDX_W || EXP_W < 4) begin : g_bad_fmt
      $error("rsqrt_unpack: format too narrow for the index");
   end

   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] frac;
   logic              exp_max, exp_min, frac_nz;
   logic [FRAC_W:0]   sig;
   logic [LZW-1:0]    lz;
   logic              seen;
   logic [EXP_W-1:0]  e_eff;
   logic [SW-1:0]     u;
   logic signed [SW-1:0] nu, rexp;
   logic [IDX_W-1:0]  top9;

   assign ex      = mag[EXP_W+FRAC_W-1:FRAC_W];
   assign frac    = mag[FRAC_W-1:0];
   assign exp_max = &ex;
   assign exp_min = ~|ex;
   assign frac_nz = |frac;

   always_comb begin
      if (exp_max)
         kind = frac_nz ? (frac[FRAC_W-1] ? K_QNAN : K_SNAN) : K_INF;
      else if (exp_min && (!frac_nz || ftz))
         kind = K_ZERO;
      else
         kind = K_FIN;
   end

   assign flushed = exp_min & frac_nz & ftz;

   // significand with hidden bit, then leading-zero count
   assign sig = {~exp_min, frac};

   always_comb begin
      lz   = '0;
      seen = 1'b0;
      for (int k = FRAC_W; k >= 0; k--) begin
         if (!seen) begin
            if (sig[k]) seen = 1'b1;
            else        lz   = lz + LZW'(1);
         end
      end
   end

   // unbiased exponent of the leading one
   assign e_eff = exp_min ? EXP_W'(1) : ex;
   assign u     = {3'b000, e_eff} - SW'(BIAS) - SW'(lz);

   // -(u+1) is the bitwise complement; halve with sign extension
   assign nu     = ~u;
   assign rexp   = nu >>> 1;
   assign rexp_b = EXP_W'(rexp + SW'(BIAS));

   // leading one plus eight following bits
   assign top9 = IDX_W'((sig << lz) >> (FRAC_W - 8));
   assign idx  = u[0] ? top9 : {1'b0, top9[IDX_W-1:1]};

endmodule

// File: rtl/rsqrt_pack.sv
module rsqrt_pack
   import rsqrt_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op,
   input  kind_e                 kind,
   input  logic                  flushed,
   input  logic [EXP_W-1:0]      rexp_b,
   input  logic [EST_W-1:0]      est,
   input  logic                  dnan_mode,
   output logic [EXP_W+FRAC_W:0] word,
   output logic [2:0]            raise   // {idc, dzc, ioc}
);
   localparam int W = 1 + EXP_W + FRAC_W;

   if (FRAC_W < EST_W) begin : g_bad_frac
      $error("rsqrt_pack: fraction narrower than estimate");
   end

   logic         sgn;
   logic [W-1:0] dnan_w, inf_w, fin_w, qnan_w;

   assign sgn    = op[W-1];
   assign dnan_w = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   assign inf_w  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   assign fin_w  = {1'b0, rexp_b, est, {(FRAC_W-EST_W){1'b0}}};
   assign qnan_w = op | (W'(1) << (FRAC_W - 1));

   always_comb begin
      word  = '0;
      raise = 3'b000;
      unique case (kind)
         K_QNAN, K_SNAN: begin
            word     = dnan_mode ? dnan_w : qnan_w;
            raise[0] = (kind == K_SNAN);
         end
         K_ZERO: begin
            word     = inf_w;
            raise[1] = 1'b1;
            raise[2] = flushed;
         end
         K_INF, K_FIN: begin
            if (sgn) begin
               word     = dnan_w;
               raise[0] = 1'b1;
            end else begin
               word = (kind == K_INF) ? '0 : fin_w;
            end
         end
         default: word = '0;
      endcase
   end

endmodule

// File: rtl/rsqrt_estimator.sv
module rsqrt_estimator
   import rsqrt_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [XW-1:0] in_op,
   input  logic          in_dbl,
   input  logic          ctl_ftz,
   input  logic          ctl_dnan,
   input  logic          flag_clr,
   output logic          out_valid,
   output logic [XW-1:0] out_res,
   output logic          flag_ioc,
   output logic          flag_dzc,
   output logic          flag_idc
);
   logic [IDX_W-1:0] idx_f   [NFMT];
   logic [XW-1:0]    word_f  [NFMT];
   logic [2:0]       raise_f [NFMT];
   logic [EST_W-1:0] est;
   logic [XW-1:0]    res_sel;
   logic [2:0]       raise_sel;

   for (genvar f = 0; f < NFMT; f++) begin : g_fmt
      localparam int EW = fmt_exp_w(f);
      localparam int FW = fmt_frac_w(f);
      localparam int OW = 1 + EW + FW;

      if (OW > XW) begin : g_bad_width
         $error("rsqrt_estimator: format wider than the operand word");
      end

      kind_e          kind;
      logic           flushed;
      logic [EW-1:0]  rexp_b;
      logic [OW-1:0]  word;

      rsqrt_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack (
         .mag     (in_op[OW-2:0]),
         .ftz     (ctl_ftz),
         .kind    (kind),
         .flushed (flushed),
         .idx     (idx_f[f]),
         .rexp_b  (rexp_b)
      );

      rsqrt_pack #(.EXP_W(EW), .FRAC_W(FW)) u_pack (
         .op        (in_op[OW-1:0]),
         .kind      (kind),
         .flushed   (flushed),
         .rexp_b    (rexp_b),
         .est       (est),
         .dnan_mode (ctl_dnan),
         .word      (word),
         .raise     (raise_f[f])
      );

      assign word_f[f] = XW'(word);
   end

   rsqrt_lut u_lut (
      .idx (idx_f[in_dbl]),
      .est (est)
   );

   assign res_sel   = word_f[in_dbl];
   assign raise_sel = raise_f[in_dbl];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         flag_ioc  <= 1'b0;
         flag_dzc  <= 1'b0;
         flag_idc  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_res <= res_sel;
         flag_ioc <= (flag_ioc & ~flag_clr) | (in_valid & raise_sel[0]);
         flag_dzc <= (flag_dzc & ~flag_clr) | (in_valid & raise_sel[1]);
         flag_idc <= (flag_idc & ~flag_clr) | (in_valid & raise_sel[2]);
      end
   end

endmodule

// File: rtl/rsqrt_estimator_chk.sv
module rsqrt_estimator_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [63:0] in_op,
   input logic        in_dbl,
   input logic        flag_clr,
   input logic        out_valid,
   input logic [63:0] out_res,
   input logic        flag_ioc,
   input logic        flag_dzc,
   input logic        flag_idc
);
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_res_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_res));

   p_single_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_dbl |=> out_res[63:32] == 32'h0);

   p_zero_dz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_dbl && in_op[62:0] == 63'h0 |=> flag_dzc);

   p_neg_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_dbl && in_op == 64'hFFF0_0000_0000_0000
      |=> flag_ioc && out_res == 64'h7FF8_0000_0000_0000);

   p_pos_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_dbl && in_op[31:0] == 32'h7F80_0000 |=> out_res == 64'h0);

   p_sticky_ioc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ioc && !flag_clr |=> flag_ioc);

   p_sticky_dzc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_dzc && !flag_clr |=> flag_dzc);

   p_sticky_idc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_idc && !flag_clr |=> flag_idc);

   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !in_valid |=> !flag_ioc && !flag_dzc && !flag_idc);

   p_rise_with_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_dzc) || $rose(flag_ioc) || $rose(flag_idc) |-> out_valid);

endmodule

bind rsqrt_estimator rsqrt_estimator_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_dbl    (in_dbl),
   .flag_clr  (flag_clr),
   .out_valid (out_valid),
   .out_res   (out_res),
   .flag_ioc  (flag_ioc),
   .flag_dzc  (flag_dzc),
   .flag_idc  (flag_idc)
);

// File: tb/tb_rsqrt_estimator.sv
`timescale 1ns/1ps
module tb_rsqrt_estimator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic        in_dbl = 1'b0;
   logic        ctl_ftz = 1'b0;
   logic        ctl_dnan = 1'b0;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [63:0] out_res;
   logic        flag_ioc, flag_dzc, flag_idc;

   int n_tests = 0;
   int n_fail  = 0;
   int tbl [512];
   logic [2:0] sf = 3'b000;   // expected sticky flags {idc,dzc,ioc}

   typedef struct packed {
      logic [63:0] res;
      logic [2:0]  flg;
   } exp_t;

   exp_t  exp_q [$];
   string tag_q [$];

   always #2.5 clk = ~clk;

   rsqrt_estimator dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
      .in_dbl (in_dbl), .ctl_ftz (ctl_ftz), .ctl_dnan (ctl_dnan),
      .flag_clr (flag_clr), .out_valid (out_valid), .out_res (out_res),
      .flag_ioc (flag_ioc), .flag_dzc (flag_dzc), .flag_idc (flag_idc)
   );

   function automatic int tb_entry(input int i);
      longint a, b;
      if (i < 128) return 0;
      a = (i < 256) ? longint'(2 * i + 1) : longint'((i | 1) * 2);
      b = 512;
      while (a * (b + 1) * (b + 1) < longint'(268435456)) b++;
      return int'(((b + 1) / 2) & 255);
   endfunction

   task automatic model(input logic [63:0] op, input bit dbl, input bit ftz,
                        input bit dn, output logic [63:0] res,
                        output logic [2:0] rz);
      int fw, ew, bias, h, s, rexp, sh;
      logic [63:0] w, frac, mant, dnan, emax, idx;
      logic sgn;
      longint e, ex;
      fw   = dbl ? 52 : 23;
      ew   = dbl ? 11 : 8;
      bias = dbl ? 1023 : 127;
      w    = dbl ? op : {32'h0, op[31:0]};
      sgn  = w[fw + ew];
      emax = (64'd1 << ew) - 1;
      e    = longint'((w >> fw) & emax);
      frac = w & ((64'd1 << fw) - 1);
      dnan = dbl ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
      rz   = 3'b000;
      if (e == longint'(emax) && frac != 0) begin
         if (!frac[fw - 1]) rz[0] = 1'b1;
         res = dn ? dnan : (w | (64'd1 << (fw - 1)));
      end else if (e == 0 && (frac == 0 || ftz)) begin
         rz[1] = 1'b1;
         if (frac != 0) rz[2] = 1'b1;
         res = (64'(sgn) << (fw + ew)) | (emax << fw);
      end else if (sgn) begin
         rz[0] = 1'b1;
         res = dnan;
      end else if (e == longint'(emax)) begin
         res = 64'h0;
      end else begin
         if (e == 0) begin mant = frac; ex = 1 - bias - fw; end
         else begin mant = frac | (64'd1 << fw); ex = e - bias - fw; end
         h = 0;
         for (int k = 0; k < 64; k++) if (mant[k]) h = k;
         s    = int'(ex) + h;
         rexp = (-(s + 1)) >>> 1;
         sh   = ((s & 1) == 0) ? h - 7 : h - 8;
         idx  = (sh >= 0) ? (mant >> sh) : (mant << (-sh));
         idx  = idx & 64'h1FF;
         res  = (64'(rexp + bias) << fw) | (64'(tbl[int'(idx)]) << (fw - 8));
      end
   endtask

   task automatic drive(input logic [63:0] op, input bit dbl, input bit ftz,
                        input bit dn, input bit clr, input bit use_want,
                        input logic [63:0] want, input string tag);
      logic [63:0] r;
      logic [2:0]  rz;
      exp_t        it;
      model(op, dbl, ftz, dn, r, rz);
      if (use_want) r = want;
      if (clr) sf = 3'b000;
      sf = sf | rz;
      it.res = r;
      it.flg = sf;
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_dbl = dbl;
      ctl_ftz = ftz; ctl_dnan = dn; flag_clr = clr;
      exp_q.push_back(it);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic check_flags_now(input logic [2:0] want, input string tag);
      n_tests++;
      if ({flag_idc, flag_dzc, flag_ioc} !== want) begin
         n_fail++;
         $display("FAIL %s flags actual=%b expected=%b", tag,
                  {flag_idc, flag_dzc, flag_ioc}, want);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R1 unexpected result actual=%h expected=none", out_res);
         end else begin
            exp_t  it;
            string tg;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (out_res !== it.res || {flag_idc, flag_dzc, flag_ioc} !== it.flg) begin
               n_fail++;
               $display("FAIL %s actual=%h/%b expected=%h/%b", tg, out_res,
                        {flag_idc, flag_dzc, flag_ioc}, it.res, it.flg);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) tbl[i] = tb_entry(i);
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || out_res !== 64'h0 ||
          {flag_idc, flag_dzc, flag_ioc} !== 3'b000) begin
         n_fail++;
         $display("FAIL R1 R12 reset actual=%b/%h/%b expected=0/0/000", out_valid,
                  out_res, {flag_idc, flag_dzc, flag_ioc});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // fixed anchors
      drive(64'h3F80_0000, 0, 0, 0, 0, 1, 64'h3F7F_8000, "R8 R9 even 1.0 single");
      drive(64'h3FF0_0000_0000_0000, 1, 0, 0, 0, 1, 64'h3FEF_F000_0000_0000, "R2 R8 1.0 double");
      drive(64'h4000_0000, 0, 0, 0, 0, 1, 64'h3F34_8000, "R9 odd 2.0 single");
      drive(64'h4080_0000, 0, 0, 0, 0, 1, 64'h3EFF_8000, "R8 4.0 single");
      drive(64'hDEAD_BEEF_3F80_0000, 0, 0, 0, 0, 1, 64'h3F7F_8000, "R2 upper ignored");
      // subnormals, no flush
      drive(64'h0000_0001, 0, 0, 0, 0, 0, 0, "R10 min subnormal single");
      drive(64'h0040_0000, 0, 0, 0, 0, 0, 0, "R10 subnormal single");
      drive(64'h0000_0000_0000_0001, 1, 0, 0, 0, 0, 0, "R10 min subnormal double");
      drive(64'h000F_FFFF_FFFF_FFFF, 1, 0, 0, 0, 0, 0, "R10 max subnormal double");
      // zeros, infinities, negatives
      drive(64'h0000_0000, 0, 0, 0, 0, 1, 64'h7F80_0000, "R5 +0 single");
      drive(64'h8000_0000_0000_0000, 1, 0, 0, 0, 1, 64'hFFF0_0000_0000_0000, "R5 -0 double");
      drive(64'h7F80_0000, 0, 0, 0, 0, 1, 64'h0, "R7 +inf single");
      drive(64'hBF80_0000, 0, 0, 0, 0, 1, 64'h7FC0_0000, "R6 -1.0 single");
      drive(64'hFFF0_0000_0000_0000, 1, 0, 0, 0, 0, 0, "R6 -inf double");
      drive(64'h8000_0010, 0, 0, 0, 0, 0, 0, "R6 neg subnormal no flush");
      // NaNs
      drive(64'h7FC1_2345, 0, 0, 0, 0, 1, 64'h7FC1_2345, "R3 qnan single");
      drive(64'hFF81_2345, 0, 0, 0, 0, 1, 64'hFFC1_2345, "R3 snan single");
      drive(64'h7FF0_0000_0000_0ABC, 1, 0, 0, 0, 0, 0, "R3 snan double");
      drive(64'h7FC1_2345, 0, 0, 1, 0, 1, 64'h7FC0_0000, "R4 qnan default");
      drive(64'hFFF0_0000_0000_0001, 1, 0, 1, 0, 1, 64'h7FF8_0000_0000_0000, "R4 snan default");
      idle();
      @(negedge clk);
      // clear with no operand
      flag_clr = 1'b1; sf = 3'b000;
      @(negedge clk);
      flag_clr = 1'b0;
      check_flags_now(3'b000, "R12 clear");
      // flush-to-zero
      drive(64'h0000_0001, 0, 1, 0, 0, 1, 64'h7F80_0000, "R11 flush single");
      drive(64'h8000_0000_0000_0005, 1, 1, 0, 0, 1, 64'hFFF0_0000_0000_0000, "R11 flush neg double");
      drive(64'h3F80_0000, 0, 1, 0, 0, 0, 0, "R12 sticky held");
      idle();
      @(negedge clk);
      // clear coinciding with a new exception
      drive(64'h0000_0000, 0, 0, 0, 1, 0, 0, "R12 clear with raise");
      idle();
      @(negedge clk);
      check_flags_now(3'b010, "R12 raise beats clear");

      // random operands, both formats, all modes
      for (int n = 0; n < 300; n++) begin
         logic [63:0] op;
         bit d, z, q;
         op = {$urandom(), $urandom()};
         d = $urandom_range(0, 1);
         z = ($urandom_range(0, 3) == 0);
         q = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 1) == 1) op[63] = 1'b0;
         if ($urandom_range(0, 1) == 1) op[31] = 1'b0;
         if ($urandom_range(0, 7) == 0) begin
            if (d) op[62:52] = '0; else op[30:23] = '0;
         end
         drive(op, d, z, q, 0, 0, 0, "R8 R9 random");
      end
      idle();
      repeat (4) @(negedge clk);

      n_tests++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule